// File: doc/BRIEF.md
# Single-Phase H-Bridge Commutation Logic

This block turns a digital Hall polarity bit into gate commands for a single-phase full bridge. Each leg has a high-side P-channel switch, enabled by an active-low output, and a low-side N-channel switch, enabled by an active-high output. The Hall bit first passes through a synchronizer and a majority filter. The filtered polarity then picks one of two drive phases.

Three control inputs act on the drive:
- **PWM off-time.** A low `pwm_on` turns both upper switches off and both lower switches on, so the coil current recirculates in the lower devices.
- **Over-current.** `over_cur` forces the same low-side recirculation state.
- **Lock.** `lock` forces both upper switches off while the low side of the current phase stays on.

When the polarity changes, all four switches stay off for a programmable dead time before the new phase is applied. A tachometer bit, `fg`, follows the applied phase.

All inputs are plain level controls sampled on `clk`. There is no data stream and no handshake. Every output is registered, so a change on `pwm_on`, `over_cur` or `lock` reaches the gates one clock later.

Top module: `hbridge_commutator`

## Requirements
- R1: With `hall_pol`=0 (negative Hall terminal high), `pwm_on`=1, `over_cur`=0 and `lock`=0, the outputs settle to `hs1_n`=0, `ls2`=1, `hs2_n`=1, `ls1`=0.
- R2: With `hall_pol`=1 under the same conditions, the outputs settle to `hs2_n`=0, `ls1`=1, `hs1_n`=1, `ls2`=0.
- R3: `fg` is 0 while the `hall_pol`=0 phase is applied and 1 while the `hall_pol`=1 phase is applied. It changes in the same cycle the new phase first drives, and holds its old value during the dead time.
- R4: When `pwm_on`=0 in a running phase, one cycle later both high sides are off (`hs1_n`=`hs2_n`=1) and both low sides are on (`ls1`=`ls2`=1).
- R5: When `over_cur`=1 in a running phase, one cycle later the bridge is in the same low-side recirculation state as R4, whatever `pwm_on` is.
- R6: When `lock`=1 in a running phase, one cycle later both high sides are off and only the low side of the current phase stays on. This holds regardless of `pwm_on` and `over_cur`.
- R7: After a filtered polarity change, all four switches are off for exactly `DEAD_CYCLES` clock cycles (default 8), then the new phase is applied. The old phase is still visible 7 cycles after the input change, and the new phase appears 8 + `DEAD_CYCLES` cycles after it.
- R8: `hall_pol` passes a 2-flop synchronizer and a 4-sample window. The filtered value becomes 1 when at least 3 samples are 1, becomes 0 when at most 1 sample is 1, and holds on a 2–2 tie. A 1- or 2-cycle pulse on `hall_pol` therefore changes nothing at the outputs.
- R9: From reset until the first full filter window, all switches are off (`hs1_n`=`hs2_n`=1, `ls1`=`ls2`=0) and `fg`=1. The first phase is applied 9 cycles after reset release, with no dead time.
- R10: A leg never has its high side and its low side enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_pol | input | 1 | Hall polarity: 1 when the positive Hall terminal is above the negative one |
| pwm_on | input | 1 | PWM on-time; 0 requests low-side recirculation |
| over_cur | input | 1 | Over-current flag; 1 requests low-side recirculation |
| lock | input | 1 | Lock-protection flag; 1 forces both high sides off |
| hs1_n | output | 1 | Leg 1 high-side enable, active low |
| hs2_n | output | 1 | Leg 2 high-side enable, active low |
| ls1 | output | 1 | Leg 1 low-side enable, active high |
| ls2 | output | 1 | Leg 2 low-side enable, active high |
| fg | output | 1 | Tachometer bit following the applied phase |

## Verification
A stuck or mis-loaded dead-time counter shows up at the ports as an all-off window that is shorter or longer than `DEAD_CYCLES`. It is visible within about 16 cycles of the Hall edge that starts it. A wrong applied phase or a bad priority decode appears on the gate pins one cycle after the offending input. It can also appear as a leg with both switches on in that same cycle. A filter that counts its window wrongly either lets a short Hall pulse reach the bridge about 7 cycles later, or moves the start of commutation off cycle 7.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DEAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/hbc_hall_filter.sv
module hbc_hall_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_in,
  output logic filt_o,
  output logic valid_o
);
  localparam int LAT = SYNC_STAGES + TAPS;
  localparam int FW  = $clog2(LAT + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        win_q;
  logic [FW-1:0]          fill_q;
  logic                   filt_q;
  logic                   valid_q;
  int                     ones;

  always_comb begin
    ones = 0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + int'(win_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      win_q   <= '0;
      fill_q  <= '0;
      filt_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], hall_in};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      if (fill_q != FW'(LAT)) begin
        fill_q <= fill_q + 1'b1;
      end else begin
        valid_q <= 1'b1;
        if (ones * 2 > TAPS) begin
          filt_q <= 1'b1;
        end else if (ones * 2 < TAPS) begin
          filt_q <= 1'b0;
        end
      end
    end
  end

  assign filt_o  = filt_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/hbc_phase_seq.sv
module hbc_phase_seq
  import hbc_pkg::*;
#(
  parameter int DEAD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       filt_i,
  input  logic       valid_i,
  output seq_state_e state_o,
  output logic       phase_o
);
  localparam int CW = $clog2(DEAD_CYCLES + 1);

  seq_state_e    state_q;
  logic          phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (valid_i) begin
            state_q <= SEQ_RUN;
            phase_q <= filt_i;
          end
        end
        SEQ_RUN: begin
          if (filt_i != phase_q) begin
            state_q <= SEQ_DEAD;
            cnt_q   <= CW'(DEAD_CYCLES - 1);
          end
        end
        SEQ_DEAD: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_RUN;
            phase_q <= filt_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/hbc_gate_map.sv
module hbc_gate_map
  import hbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  seq_state_e          state_i,
  input  logic                phase_i,
  input  logic                pwm_on,
  input  logic                over_cur,
  input  logic                lock,
  output logic [NUM_LEGS-1:0] hs_n_o,
  output logic [NUM_LEGS-1:0] ls_o,
  output logic                fg_o
);
  logic                running;
  logic                recirc;
  logic [NUM_LEGS-1:0] hs_on;
  logic [NUM_LEGS-1:0] ls_on;
  logic [NUM_LEGS-1:0] hs_n_q;
  logic [NUM_LEGS-1:0] ls_q;
  logic                fg_q;
  logic                fg_nxt;

  assign running = (state_i == SEQ_RUN);
  assign recirc  = !lock && (!pwm_on || over_cur);

  // leg l sources current when the phase equals l, sinks otherwise
  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    assign hs_on[l] = running && !lock && pwm_on && !over_cur && (phase_i == 1'(l));
    assign ls_on[l] = running && ((phase_i != 1'(l)) || recirc);
  end

  always_comb begin
    case (state_i)
      SEQ_RUN:  fg_nxt = phase_i;
      SEQ_DEAD: fg_nxt = fg_q;
      default:  fg_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_n_q <= '1;
      ls_q   <= '0;
      fg_q   <= 1'b1;
    end else begin
      hs_n_q <= ~hs_on;
      ls_q   <= ls_on;
      fg_q   <= fg_nxt;
    end
  end

  assign hs_n_o = hs_n_q;
  assign ls_o   = ls_q;
  assign fg_o   = fg_q;
endmodule

// File: rtl/hbridge_commutator.sv
module hbridge_commutator
  import hbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 4,
  parameter int DEAD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_pol,
  input  logic pwm_on,
  input  logic over_cur,
  input  logic lock,
  output logic hs1_n,
  output logic hs2_n,
  output logic ls1,
  output logic ls2,
  output logic fg
);
  logic                filt;
  logic                filt_valid;
  seq_state_e          state;
  logic                phase;
  logic [NUM_LEGS-1:0] hs_n;
  logic [NUM_LEGS-1:0] ls;

  hbc_hall_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .TAPS       (FILT_TAPS)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .hall_in(hall_pol),
    .filt_o (filt),
    .valid_o(filt_valid)
  );

  hbc_phase_seq #(
    .DEAD_CYCLES(DEAD_CYCLES)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .filt_i (filt),
    .valid_i(filt_valid),
    .state_o(state),
    .phase_o(phase)
  );

  hbc_gate_map u_gates (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state),
    .phase_i (phase),
    .pwm_on  (pwm_on),
    .over_cur(over_cur),
    .lock    (lock),
    .hs_n_o  (hs_n),
    .ls_o    (ls),
    .fg_o    (fg)
  );

  assign hs1_n = hs_n[0];
  assign hs2_n = hs_n[1];
  assign ls1   = ls[0];
  assign ls2   = ls[1];
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker (
  input logic clk,
  input logic rst_n,
  input logic pwm_on,
  input logic over_cur,
  input logic lock,
  input logic hs1_n,
  input logic hs2_n,
  input logic ls1,
  input logic ls2,
  input logic fg
);
  a_r10_no_shoot_leg1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hs1_n && ls1));

  a_r10_no_shoot_leg2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hs2_n && ls2));

  a_r4_r5_recirc_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_on || over_cur) |=> (hs1_n && hs2_n));

  a_r6_lock_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (hs1_n && hs2_n));

  a_r3_fg_phase_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !hs1_n |-> !fg);

  a_r3_fg_phase_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !hs2_n |-> fg);

  a_r7_hs2_after_hs1_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs2_n) |-> $past(hs1_n));

  a_r7_hs1_after_hs2_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs1_n) |-> $past(hs2_n));
endmodule

bind hbridge_commutator hbc_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_on  (pwm_on),
  .over_cur(over_cur),
  .lock    (lock),
  .hs1_n   (hs1_n),
  .hs2_n   (hs2_n),
  .ls1     (ls1),
  .ls2     (ls2),
  .fg      (fg)
);

// File: tb/hbridge_commutator_tb.sv
`timescale 1ns/1ps
module hbridge_commutator_tb;
  localparam int DEAD = 8;
  localparam int HALL_LAT = 7; // cycles from Hall input change to start of dead time

  // expected vectors: {hs1_n, hs2_n, ls1, ls2, fg}
  localparam logic [4:0] V_INIT = 5'b11001;
  localparam logic [4:0] V_A    = 5'b01010;
  localparam logic [4:0] V_B    = 5'b10101;
  localparam logic [4:0] V_OFFA = 5'b11000;
  localparam logic [4:0] V_OFFB = 5'b11001;
  localparam logic [4:0] V_RCA  = 5'b11110;
  localparam logic [4:0] V_RCB  = 5'b11111;
  localparam logic [4:0] V_LKA  = 5'b11010;
  localparam logic [4:0] V_LKB  = 5'b11101;

  typedef struct {
    int         cyc;
    logic [4:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hall_pol = 1'b0;
  logic pwm_on = 1'b1;
  logic over_cur = 1'b0;
  logic lock = 1'b0;
  logic hs1_n, hs2_n, ls1, ls2, fg;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  exp_t e_cur;

  always #2 clk = ~clk;

  hbridge_commutator #(.DEAD_CYCLES(DEAD)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .hall_pol(hall_pol),
    .pwm_on  (pwm_on),
    .over_cur(over_cur),
    .lock    (lock),
    .hs1_n   (hs1_n),
    .hs2_n   (hs2_n),
    .ls1     (ls1),
    .ls2     (ls2),
    .fg      (fg)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic expect_at(input int c, input logic [4:0] v, input string tag);
    exp_t e;
    e.cyc = c;
    e.v   = v;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops every expectation that is due and compares it with the pins
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        e_cur = sb_q.pop_front();
        n_chk++;
        if (e_cur.cyc != cyc || {hs1_n, hs2_n, ls1, ls2, fg} != e_cur.v) begin
          n_fail++;
          $display("FAIL %s at cycle %0d: got %b expected %b (due cycle %0d)",
                   e_cur.tag, cyc, {hs1_n, hs2_n, ls1, ls2, fg}, e_cur.v, e_cur.cyc);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: all off before the first full filter window, first phase at cycle 9
    expect_at(2, V_INIT, "R9");
    expect_at(8, V_INIT, "R9");
    expect_at(9, V_A, "R1 R9");
    rst_n = 1'b1;

    wait_cyc(12); pwm_on = 1'b0;                  // R4
    expect_at(13, V_RCA, "R4");
    wait_cyc(14); pwm_on = 1'b1;
    expect_at(15, V_A, "R1");

    wait_cyc(16); over_cur = 1'b1;                // R5
    expect_at(17, V_RCA, "R5");
    wait_cyc(17); pwm_on = 1'b0;
    expect_at(18, V_RCA, "R5");
    wait_cyc(18); pwm_on = 1'b1; over_cur = 1'b0;
    expect_at(19, V_A, "R1");

    wait_cyc(20); lock = 1'b1; pwm_on = 1'b0; over_cur = 1'b1;   // R6 priority
    expect_at(21, V_LKA, "R6");
    wait_cyc(22); lock = 1'b0; pwm_on = 1'b1; over_cur = 1'b0;
    expect_at(23, V_A, "R1");

    wait_cyc(30); hall_pol = 1'b1;                // R7 / R2 / R3
    expect_at(30 + HALL_LAT, V_A, "R7");
    expect_at(30 + HALL_LAT + 1, V_OFFA, "R7 R3");
    expect_at(30 + HALL_LAT + DEAD, V_OFFA, "R7 R3");
    expect_at(30 + HALL_LAT + DEAD + 1, V_B, "R2 R3 R7");

    wait_cyc(50); pwm_on = 1'b0;
    expect_at(51, V_RCB, "R4");
    wait_cyc(52); pwm_on = 1'b1;
    expect_at(53, V_B, "R2");
    wait_cyc(54); lock = 1'b1;
    expect_at(55, V_LKB, "R6");
    wait_cyc(56); lock = 1'b0;
    expect_at(57, V_B, "R2");

    wait_cyc(60); hall_pol = 1'b0;                // R8: one-cycle pulse
    wait_cyc(61); hall_pol = 1'b1;
    for (int k = 62; k <= 80; k += 3) expect_at(k, V_B, "R8");
    wait_cyc(85); hall_pol = 1'b0;                // R8: two-cycle pulse (tie holds)
    wait_cyc(87); hall_pol = 1'b1;
    for (int k = 88; k <= 104; k += 4) expect_at(k, V_B, "R8");

    wait_cyc(110); hall_pol = 1'b0;               // R7 in the other direction
    expect_at(110 + HALL_LAT, V_B, "R7");
    expect_at(110 + HALL_LAT + 1, V_OFFB, "R7 R3");
    expect_at(110 + HALL_LAT + DEAD, V_OFFB, "R7 R3");
    expect_at(110 + HALL_LAT + DEAD + 1, V_A, "R1 R3 R7");

    wait_cyc(140); hall_pol = 1'b1;               // over-current inside dead time
    expect_at(140 + HALL_LAT, V_A, "R7");
    expect_at(140 + HALL_LAT + 1, V_OFFA, "R7");
    wait_cyc(150); pwm_on = 1'b0; over_cur = 1'b1;
    expect_at(151, V_OFFA, "R7 R5");
    expect_at(140 + HALL_LAT + DEAD, V_OFFA, "R7");
    expect_at(140 + HALL_LAT + DEAD + 1, V_RCB, "R5 R7");
    wait_cyc(158); pwm_on = 1'b1; over_cur = 1'b0;
    expect_at(159, V_B, "R2 R10");

    wait_cyc(170);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 pending expectations: got %0d left expected 0", sb_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog (R7): got cycle %0d expected end by 170", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule